// File: doc/BRIEF.md
# Ethernet Controller Mode Register and Control Decoder

This block holds the mode control word of a 10 Mb/s Ethernet MAC and turns its fields into the control levels that the rest of the controller uses. Software writes the word over a simple address/data/write-enable bus. A write takes effect only while the controller reports that it is stopped. A write made while the controller runs is dropped. The stored word can be read back at any time. An asynchronous hard reset clears the word, and so does a synchronous soft reset.

The decode is combinational and does not wait on a clock. It produces five things:

- The physical port, either AUI or twisted pair, or an invalid flag. When auto-select is off, the choice comes from a two-bit field. When auto-select is on, it comes from the link-status input.
- A two-bit loopback mode.
- The transmit attempt limit, together with a retry-error flag that compares an attempt count against that limit.
- A forced-collision enable, which is passed on only while the block is in internal loopback.
- A per-frame decision on whether to append the FCS. A flag on the start-of-packet descriptor can override the global disable bit.

Top module: `enet_mode_ctl`

## Requirements
- R1: A write updates the stored word only when wr_en_i is 1, stop_i is 1 and addr_i equals REG_ADDR, all at the same clock edge. A write while stop_i is 0, or a write to any other address, leaves the word unchanged.
- R2: Hard reset (rst_n low, asynchronous) and soft reset (soft_rst_i high at a clock edge) each clear the stored word to zero. Soft reset takes priority over a write at the same edge.
- R3: rdata_o always shows the stored word zero-extended to DATA_W. The field positions are: bits 1:0 port code, bit 2 loopback enable, bit 3 internal loopback, bit 4 codec bypass, bit 5 single attempt, bit 6 force collision, bit 7 FCS disable.
- R4: With auto_sel_i=1, the port is twisted pair (port_tp_o=1) when link_pass_i=1 and AUI (port_aui_o=1) when link_pass_i=0, whatever the port code holds. In this case port_bad_o=0.
- R5: With auto_sel_i=0, port code 00 selects AUI and code 01 selects twisted pair. Codes 10 and 11 drive port_bad_o=1 and select neither port. Exactly one of the three port outputs is high at all times.
- R6: lpbk_mode_o is 0 when loopback enable is 0 (normal operation). It is 1 when loopback enable is 1 and internal loopback is 0 (external). It is 2 when both are 1 and codec bypass is 0 (internal, codec included). It is 3 when all three are 1 (internal, codec excluded).
- R7: max_tries_o is 1 when the single-attempt bit is 1 and TRY_MAX (default 16) when it is 0. retry_err_o is 1 exactly when tx_attempts_i is greater than max_tries_o.
- R8: force_col_o equals the force-collision bit while lpbk_mode_o is 2 or 3, and is 0 in every other mode.
- R9: append_fcs_o is 1 when sop_i and add_fcs_i are both 1. Otherwise it equals the inverse of the FCS-disable bit.
- R10: add_fcs_i has no effect while sop_i is 0.
- R11: Changing stop_i without a write leaves the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst_i | input | 1 | Synchronous soft reset, active high |
| stop_i | input | 1 | Controller stopped status; enables writes |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Write address |
| wdata_i | input | DATA_W | Write data; the low 8 bits are stored |
| rdata_o | output | DATA_W | Stored word, zero-extended |
| auto_sel_i | input | 1 | Port auto-select enable |
| link_pass_i | input | 1 | Twisted-pair link status, 1 = pass |
| sop_i | input | 1 | Current descriptor marks start of packet |
| add_fcs_i | input | 1 | Descriptor add-FCS flag |
| tx_attempts_i | input | CNT_W | Attempts made on the current frame |
| port_aui_o | output | 1 | AUI port selected |
| port_tp_o | output | 1 | Twisted-pair port selected |
| port_bad_o | output | 1 | Reserved port code in use |
| lpbk_mode_o | output | 2 | Loopback mode code |
| force_col_o | output | 1 | Forced-collision enable to collision logic |
| max_tries_o | output | CNT_W | Transmit attempt limit |
| retry_err_o | output | 1 | Attempt count exceeds the limit |
| append_fcs_o | output | 1 | Append FCS to this frame |

## Verification
The bench goes after the write gate. A design that ignored stop_i would take random running-state writes, and the readback would show them. It also drives soft reset together with a write at the same edge, where a wrong priority would leave data in place of zero. A sweep of auto-select against link status would expose a decoder that let the port code win. A sweep of all codes would expose a reserved code that selects a port. The bench sets force collision in external and normal loopback, where an unmasked enable would show. It drives add_fcs_i without sop_i, which would wrongly turn on the FCS for a design that does not qualify the flag. Attempt counts at 1, 2, 16 and 17 check the retry-error boundary for an off-by-one comparison.

// File: rtl/enet_mode_pkg.sv
package enet_mode_pkg;

   localparam int FLD_W = 8;

   typedef enum logic [1:0] {
      LB_NONE      = 2'd0,
      LB_EXT       = 2'd1,
      LB_INT_CODEC = 2'd2,
      LB_INT_RAW   = 2'd3
   } lpbk_e;

   typedef struct packed {
      logic       no_fcs;
      logic       fcol;
      logic       one_try;
      logic       codec_byp;
      logic       intl;
      logic       loop_en;
      logic [1:0] psel;
   } mode_t;

   typedef struct packed {
      logic bad;
      logic tp;
      logic aui;
   } port_t;

endpackage

// File: rtl/enet_mode_store.sv
module enet_mode_store
   import enet_mode_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 16,
   parameter int REG_ADDR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst_i,
   input  logic              stop_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output mode_t             mode_o
);

   localparam int PAD_W = DATA_W - FLD_W;
   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

   logic [FLD_W-1:0] word_q;
   logic             wr_hit;

   assign wr_hit = wr_en_i && stop_i && (addr_i == HIT_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (soft_rst_i) begin
         word_q <= '0;
      end else if (wr_hit) begin
         word_q <= wdata_i[FLD_W-1:0];
      end
   end

   assign mode_o = mode_t'(word_q);

   generate
      if (PAD_W > 0) begin : g_pad
         assign rdata_o = {{PAD_W{1'b0}}, word_q};
      end else begin : g_nopad
         assign rdata_o = word_q;
      end
   endgenerate

endmodule

// File: rtl/enet_port_dec.sv
module enet_port_dec
   import enet_mode_pkg::*;
(
   input  logic [1:0] psel_i,
   input  logic       auto_sel_i,
   input  logic       link_pass_i,
   output port_t      port_o
);

   always_comb begin
      port_o = '0;
      if (auto_sel_i) begin
         port_o.tp  = link_pass_i;
         port_o.aui = !link_pass_i;
      end else begin
         unique case (psel_i)
            2'b00:   port_o.aui = 1'b1;
            2'b01:   port_o.tp  = 1'b1;
            default: port_o.bad = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/enet_lpbk_dec.sv
module enet_lpbk_dec
   import enet_mode_pkg::*;
(
   input  logic  loop_en_i,
   input  logic  intl_i,
   input  logic  codec_byp_i,
   input  logic  fcol_i,
   output lpbk_e mode_o,
   output logic  force_col_o
);

   logic internal;

   always_comb begin
      if (!loop_en_i)       mode_o = LB_NONE;
      else if (!intl_i)     mode_o = LB_EXT;
      else if (codec_byp_i) mode_o = LB_INT_RAW;
      else                  mode_o = LB_INT_CODEC;
   end

   assign internal    = (mode_o == LB_INT_RAW) || (mode_o == LB_INT_CODEC);
   assign force_col_o = fcol_i && internal;

endmodule

// File: rtl/enet_tx_policy.sv
module enet_tx_policy #(
   parameter int TRY_MAX = 16,
   parameter int CNT_W   = 6
) (
   input  logic             one_try_i,
   input  logic             no_fcs_i,
   input  logic             sop_i,
   input  logic             add_fcs_i,
   input  logic [CNT_W-1:0] attempts_i,
   output logic [CNT_W-1:0] max_tries_o,
   output logic             retry_err_o,
   output logic             append_fcs_o
);

   localparam logic [CNT_W-1:0] LIM_FULL = CNT_W'(TRY_MAX);
   localparam logic [CNT_W-1:0] LIM_ONE  = CNT_W'(1);

   logic frame_force;

   assign max_tries_o  = one_try_i ? LIM_ONE : LIM_FULL;
   assign retry_err_o  = attempts_i > max_tries_o;
   assign frame_force  = sop_i & add_fcs_i;
   assign append_fcs_o = frame_force | ~no_fcs_i;

endmodule

// File: rtl/enet_mode_ctl.sv
module enet_mode_ctl
   import enet_mode_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 16,
   parameter int REG_ADDR = 6,
   parameter int TRY_MAX  = 16,
   localparam int CNT_W   = $clog2(TRY_MAX) + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst_i,
   input  logic              stop_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic              auto_sel_i,
   input  logic              link_pass_i,
   input  logic              sop_i,
   input  logic              add_fcs_i,
   input  logic [CNT_W-1:0]  tx_attempts_i,
   output logic              port_aui_o,
   output logic              port_tp_o,
   output logic              port_bad_o,
   output logic [1:0]        lpbk_mode_o,
   output logic              force_col_o,
   output logic [CNT_W-1:0]  max_tries_o,
   output logic              retry_err_o,
   output logic              append_fcs_o
);

   generate
      if (DATA_W < FLD_W) begin : g_bad_data_w
         $error("enet_mode_ctl: DATA_W must hold the mode word");
      end
      if (ADDR_W < 1 || REG_ADDR < 0 || REG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("enet_mode_ctl: REG_ADDR does not fit ADDR_W");
      end
      if (TRY_MAX < 2) begin : g_bad_try
         $error("enet_mode_ctl: TRY_MAX must be at least 2");
      end
   endgenerate

   mode_t mode;
   port_t port;
   lpbk_e lmode;

   enet_mode_store #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .REG_ADDR (REG_ADDR)
   ) store_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst_i (soft_rst_i),
      .stop_i     (stop_i),
      .wr_en_i    (wr_en_i),
      .addr_i     (addr_i),
      .wdata_i    (wdata_i),
      .rdata_o    (rdata_o),
      .mode_o     (mode)
   );

   enet_port_dec port_i (
      .psel_i      (mode.psel),
      .auto_sel_i  (auto_sel_i),
      .link_pass_i (link_pass_i),
      .port_o      (port)
   );

   enet_lpbk_dec lpbk_i (
      .loop_en_i   (mode.loop_en),
      .intl_i      (mode.intl),
      .codec_byp_i (mode.codec_byp),
      .fcol_i      (mode.fcol),
      .mode_o      (lmode),
      .force_col_o (force_col_o)
   );

   enet_tx_policy #(
      .TRY_MAX (TRY_MAX),
      .CNT_W   (CNT_W)
   ) pol_i (
      .one_try_i    (mode.one_try),
      .no_fcs_i     (mode.no_fcs),
      .sop_i        (sop_i),
      .add_fcs_i    (add_fcs_i),
      .attempts_i   (tx_attempts_i),
      .max_tries_o  (max_tries_o),
      .retry_err_o  (retry_err_o),
      .append_fcs_o (append_fcs_o)
   );

   assign port_aui_o  = port.aui;
   assign port_tp_o   = port.tp;
   assign port_bad_o  = port.bad;
   assign lpbk_mode_o = lmode;

endmodule

// File: rtl/enet_mode_ctl_chk.sv
module enet_mode_ctl_chk #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              soft_rst_i,
   input logic              stop_i,
   input logic              wr_en_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [DATA_W-1:0] wdata_i,
   input logic [DATA_W-1:0] rdata_o,
   input logic              auto_sel_i,
   input logic              link_pass_i,
   input logic              sop_i,
   input logic              add_fcs_i,
   input logic [CNT_W-1:0]  tx_attempts_i,
   input logic              port_aui_o,
   input logic              port_tp_o,
   input logic              port_bad_o,
   input logic [1:0]        lpbk_mode_o,
   input logic              force_col_o,
   input logic [CNT_W-1:0]  max_tries_o,
   input logic              retry_err_o,
   input logic              append_fcs_o
);

   p_run_write_dropped_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_i && !soft_rst_i) |=> $stable(rdata_o));

   p_soft_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_i |=> (rdata_o == '0));

   p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_o >> 8) == '0);

   p_auto_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
      auto_sel_i |-> (port_tp_o == link_pass_i && port_aui_o == !link_pass_i && !port_bad_o));

   p_port_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({port_bad_o, port_tp_o, port_aui_o}) == 1);

   p_lpbk_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_o[2] |-> (lpbk_mode_o == 2'd0));

   p_tries_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (max_tries_o == CNT_W'(1)) || (max_tries_o == CNT_W'(16)));

   p_fcol_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      force_col_o |-> lpbk_mode_o[1]);

   p_fcs_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sop_i && add_fcs_i) |-> append_fcs_o);

   p_fcs_nosop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !sop_i |-> (append_fcs_o == !rdata_o[7]));

   p_stop_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_i && !soft_rst_i) |=> $stable(rdata_o));

endmodule

bind enet_mode_ctl enet_mode_ctl_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W)
) chk_i (.*);

// File: tb/enet_mode_ctl_tb_top.sv
`timescale 1ns/1ps
module enet_mode_ctl_tb_top;

   localparam int ADDR_W   = 4;
   localparam int DATA_W   = 16;
   localparam int REG_ADDR = 6;
   localparam int TRY_MAX  = 16;
   localparam int CNT_W    = $clog2(TRY_MAX) + 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              soft_rst_i = 1'b0;
   logic              stop_i = 1'b0;
   logic              wr_en_i = 1'b0;
   logic [ADDR_W-1:0] addr_i = '0;
   logic [DATA_W-1:0] wdata_i = '0;
   logic [DATA_W-1:0] rdata_o;
   logic              auto_sel_i = 1'b0;
   logic              link_pass_i = 1'b0;
   logic              sop_i = 1'b0;
   logic              add_fcs_i = 1'b0;
   logic [CNT_W-1:0]  tx_attempts_i = '0;
   logic              port_aui_o, port_tp_o, port_bad_o;
   logic [1:0]        lpbk_mode_o;
   logic              force_col_o;
   logic [CNT_W-1:0]  max_tries_o;
   logic              retry_err_o;
   logic              append_fcs_o;

   always #2.5 clk = ~clk;

   enet_mode_ctl #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .REG_ADDR (REG_ADDR),
      .TRY_MAX  (TRY_MAX)
   ) dut_i (.*);

   int       n_chk = 0;
   int       n_err = 0;
   bit       ended = 1'b0;
   logic [7:0] m = '0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   function automatic int exp_port(input logic [7:0] w, input logic au, input logic lk);
      if (au) return lk ? 2 : 1;
      case (w[1:0])
         2'b00:   return 1;
         2'b01:   return 2;
         default: return 4;
      endcase
   endfunction

   function automatic int exp_lpbk(input logic [7:0] w);
      if (!w[2]) return 0;
      if (!w[3]) return 1;
      return w[4] ? 3 : 2;
   endfunction

   function automatic int exp_tries(input logic [7:0] w);
      return w[5] ? 1 : TRY_MAX;
   endfunction

   task automatic check_all();
      chk("R3 readback", int'(rdata_o), int'({8'h00, m}));
      if (auto_sel_i)
         chk("R4 auto port", int'({port_bad_o, port_tp_o, port_aui_o}), exp_port(m, auto_sel_i, link_pass_i));
      else
         chk("R5 coded port", int'({port_bad_o, port_tp_o, port_aui_o}), exp_port(m, auto_sel_i, link_pass_i));
      chk("R6 loopback", int'(lpbk_mode_o), exp_lpbk(m));
      chk("R7 tries", int'(max_tries_o), exp_tries(m));
      chk("R7 retry err", int'(retry_err_o), int'(int'(tx_attempts_i) > exp_tries(m)));
      chk("R8 force col", int'(force_col_o), int'(m[6] && exp_lpbk(m) >= 2));
      if (sop_i)
         chk("R9 fcs", int'(append_fcs_o), int'((add_fcs_i) || !m[7]));
      else
         chk("R10 fcs no sop", int'(append_fcs_o), int'(!m[7]));
   endtask

   task automatic tick();
      #1 check_all();
      @(posedge clk);
      if (soft_rst_i) m = '0;
      else if (wr_en_i && stop_i && addr_i == ADDR_W'(REG_ADDR)) m = wdata_i[7:0];
      @(negedge clk);
      soft_rst_i = 1'b0;
      wr_en_i    = 1'b0;
   endtask

   task automatic wr(input logic st, input logic [7:0] v);
      stop_i  = st;
      wr_en_i = 1'b1;
      addr_i  = ADDR_W'(REG_ADDR);
      wdata_i = {8'hA5, v};
      tick();
   endtask

   initial begin
      #(200000 * 5);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      #1 chk("R2 hard reset", int'(rdata_o), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: write while running is dropped, while stopped is taken
      wr(1'b0, 8'h5C);
      chk("R1 run write dropped", int'(rdata_o[7:0]), 0);
      wr(1'b1, 8'h5C);
      chk("R1 stopped write taken", int'(rdata_o[7:0]), 8'h5C);
      stop_i = 1'b1; wr_en_i = 1'b1; addr_i = ADDR_W'(REG_ADDR + 1); wdata_i = 16'h00FF;
      tick();
      chk("R1 other address dropped", int'(rdata_o[7:0]), 8'h5C);

      // R11: toggling stop alone keeps the word
      stop_i = 1'b0; tick();
      stop_i = 1'b1; tick();
      chk("R11 stop toggle hold", int'(rdata_o[7:0]), 8'h5C);

      // R2: soft reset wins over a same-edge write
      stop_i = 1'b1; wr_en_i = 1'b1; addr_i = ADDR_W'(REG_ADDR); wdata_i = 16'h00AA; soft_rst_i = 1'b1;
      tick();
      chk("R2 soft reset priority", int'(rdata_o), 0);

      // R4/R5: every auto-select, link and port code
      for (int c = 0; c < 4; c++) begin
         wr(1'b1, 8'(c));
         for (int a = 0; a < 4; a++) begin
            auto_sel_i = a[1]; link_pass_i = a[0];
            tick();
         end
      end
      auto_sel_i = 1'b0;

      // R6/R8: all loopback codes with force collision set
      for (int l = 0; l < 8; l++) begin
         wr(1'b1, {1'b0, 1'b1, 1'b0, 3'(l), 2'b00});
         tick();
      end

      // R7: attempt count boundaries
      wr(1'b1, 8'h00);
      foreach (tx_attempts_i[i]) ;
      tx_attempts_i = 6'd16; tick();
      tx_attempts_i = 6'd17; tick();
      wr(1'b1, 8'h20);
      tx_attempts_i = 6'd1; tick();
      tx_attempts_i = 6'd2; tick();

      // R9/R10: every FCS flag combination
      for (int d = 0; d < 2; d++) begin
         wr(1'b1, {d[0], 7'h00});
         for (int f = 0; f < 4; f++) begin
            sop_i = f[1]; add_fcs_i = f[0];
            tick();
         end
      end

      // mixed random traffic
      for (int k = 0; k < 600; k++) begin
         stop_i        = ($urandom % 2) == 0;
         wr_en_i       = ($urandom % 2) == 0;
         addr_i        = (($urandom % 10) < 7) ? ADDR_W'(REG_ADDR) : ADDR_W'($urandom);
         wdata_i       = DATA_W'($urandom);
         soft_rst_i    = ($urandom % 20) == 0;
         auto_sel_i    = ($urandom % 2) == 0;
         link_pass_i   = ($urandom % 2) == 0;
         sop_i         = ($urandom % 2) == 0;
         add_fcs_i     = ($urandom % 2) == 0;
         tx_attempts_i = CNT_W'($urandom % 20);
         tick();
      end

      // R2: asynchronous hard reset mid-run
      wr(1'b1, 8'hFF);
      rst_n = 1'b0;
      #1 chk("R2 hard reset async", int'(rdata_o), 0);
      m = '0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      tick();

      finish_run();
   end

endmodule